// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between two eight-line interrupt controller slices, a primary and a secondary, that are wired in cascade. The primary drives the processor. The secondary feeds the primary on its cascade line, line 2. Each slice's priority search is outside the block and reports a winning line, with a flag that says whether one exists. The block turns the secondary's winning state into edge events on the primary's cascade line. It also drives the processor interrupt request from the primary's winning state.

When the processor acknowledges, the block decides which slice is served and which line is served. It returns an 8-bit vector, formed from that slice's 5-bit base and the 3-bit line. It also emits one-cycle update strobes that tell each slice which request bits to clear, which in-service bit to set and whether to load a new rotation offset. A slice that has no winner at acknowledge time gets a spurious vector that points at its line 7.

Top module: `pic_ack_seq`

## Requirements
- R1: While `slv_win_vld` is high, `cas_pulse` alternates 1,0,1,0…, starting with 1 the clock after it is first sampled high. Each 1 is one edge event for primary line 2. It stays 0 while `slv_win_vld` is low.
- R2: `cpu_irq` is `mst_win_vld` registered by one clock. It is forced low in the cycle after an acknowledge is accepted and in the cycle after that. It follows `mst_win_vld` again from the next clock on.
- R3: `vec_vld` and every update strobe are high for exactly one cycle, the clock after an accepted `ack_req`. An `ack_req` sampled while `vec_vld` is high is ignored. All strobes are zero whenever `vec_vld` is low.
- R4: A primary winner on a line L other than 2 gives the vector {mst_base, L}, with strobes on the primary slice only.
- R5: A primary winner on line 2 with a secondary winner S gives {slv_base, S}. Both slices receive strobes: the primary on line 2, the secondary on line S.
- R6: A primary winner on line 2 with no secondary winner gives {slv_base, 3'd7}. Only the primary receives strobes.
- R7: No primary winner gives {mst_base, 3'd7}, with no strobes on either slice.
- R8: A served line's bit in `*_irr_clr` is set only when that line's trigger bit is 0 (edge). A trigger bit of 1 (level) leaves the request bit alone.
- R9: A served line's bit in `*_isr_set` is set when that slice's auto-EOI input is 0 and stays clear when it is 1.
- R10: A slice with auto-EOI and rotate-on-auto-EOI both set pulses `*_rot_wr` with `*_rot_val` = (served line + 1) mod 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_win_vld | input | 1 | Primary slice has a winning line |
| mst_win_line | input | 3 | Primary winning line |
| slv_win_vld | input | 1 | Secondary slice has a winning line |
| slv_win_line | input | 3 | Secondary winning line |
| mst_base | input | 5 | Primary vector base (vector bits 7:3) |
| slv_base | input | 5 | Secondary vector base (vector bits 7:3) |
| mst_aeoi | input | 1 | Primary auto-EOI enable |
| slv_aeoi | input | 1 | Secondary auto-EOI enable |
| mst_rot_aeoi | input | 1 | Primary rotate-on-auto-EOI enable |
| slv_rot_aeoi | input | 1 | Secondary rotate-on-auto-EOI enable |
| mst_trig | input | 8 | Primary trigger mode per line, 1 = level |
| slv_trig | input | 8 | Secondary trigger mode per line, 1 = level |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Returned vector |
| vec_vld | output | 1 | One-cycle valid for `vec_out` |
| cas_pulse | output | 1 | Edge event for primary cascade line 2 |
| mst_irr_clr | output | 8 | Primary request-bit clear strobe |
| mst_isr_set | output | 8 | Primary in-service set strobe |
| mst_rot_wr | output | 1 | Primary rotation offset load |
| mst_rot_val | output | 3 | Primary new rotation offset |
| slv_irr_clr | output | 8 | Secondary request-bit clear strobe |
| slv_isr_set | output | 8 | Secondary in-service set strobe |
| slv_rot_wr | output | 1 | Secondary rotation offset load |
| slv_rot_val | output | 3 | Secondary new rotation offset |

## Verification
The hardest cases to reach are the ones where both slices are served at once. In those cases the primary has won on the cascade line and the secondary's configuration differs from the primary's, so the two slices must receive different strobes from a single acknowledge. The bench drives the winner and configuration inputs directly. Its vector table pairs a primary win on line 2 with a secondary that uses auto-EOI rotation and level triggering, while the primary uses a different mix. This exposes any crossing of the two slices' configuration. A directed test holds the acknowledge high for two cycles to show that the second sample is dropped.

// File: rtl/pic_ack_pkg.sv
package pic_ack_pkg;
    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);

    typedef struct packed {
        logic [LINES-1:0] irr_clr;
        logic [LINES-1:0] isr_set;
        logic             rot_wr;
        logic [LW-1:0]    rot_val;
    } slice_upd_t;
endpackage

// File: rtl/pic_cas_fwd.sv
module pic_cas_fwd (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_req,
    output logic edge_evt
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = sec_req & ~pulse_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign edge_evt = pulse_q;

    AST_CAS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R1
endmodule

// File: rtl/pic_line_strobe.sv
module pic_line_strobe
    import pic_ack_pkg::*;
(
    input  logic             en,
    input  logic [LW-1:0]    line,
    input  logic [LINES-1:0] trig,
    input  logic             aeoi,
    input  logic             rot,
    output slice_upd_t       upd
);
    logic [LINES-1:0] sel;

    always_comb begin
        sel = '0;
        sel[line] = en;
        upd.irr_clr = sel & ~trig;
        upd.isr_set = aeoi ? '0 : sel;
        upd.rot_wr  = en & aeoi & rot;
        upd.rot_val = upd.rot_wr ? LW'(line + 1'b1) : '0;
    end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_ack_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int CAS_LINE = 2,
    localparam int BASE_W  = VEC_W - LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_win_vld,
    input  logic [LW-1:0]     mst_win_line,
    input  logic              slv_win_vld,
    input  logic [LW-1:0]     slv_win_line,
    input  logic [BASE_W-1:0] mst_base,
    input  logic [BASE_W-1:0] slv_base,
    input  logic              mst_aeoi,
    input  logic              slv_aeoi,
    input  logic              mst_rot_aeoi,
    input  logic              slv_rot_aeoi,
    input  logic [LINES-1:0]  mst_trig,
    input  logic [LINES-1:0]  slv_trig,
    input  logic              ack_req,
    output logic              cpu_irq,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_vld,
    output logic              cas_pulse,
    output logic [LINES-1:0]  mst_irr_clr,
    output logic [LINES-1:0]  mst_isr_set,
    output logic              mst_rot_wr,
    output logic [LW-1:0]     mst_rot_val,
    output logic [LINES-1:0]  slv_irr_clr,
    output logic [LINES-1:0]  slv_isr_set,
    output logic              slv_rot_wr,
    output logic [LW-1:0]     slv_rot_val
);
    localparam logic [LW-1:0] SPUR = LW'(LINES - 1);
    localparam logic [LW-1:0] CAS  = LW'(CAS_LINE);

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
        logic             irq;
        slice_upd_t       m_upd;
        slice_upd_t       s_upd;
    } seq_st_t;

    seq_st_t    st_d, st_q;
    slice_upd_t m_upd_w, s_upd_w;
    logic       accept, m_en, s_en;

    pic_cas_fwd u_cas (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_req  (slv_win_vld),
        .edge_evt (cas_pulse)
    );

    pic_line_strobe u_mst_strb (
        .en   (m_en),
        .line (mst_win_line),
        .trig (mst_trig),
        .aeoi (mst_aeoi),
        .rot  (mst_rot_aeoi),
        .upd  (m_upd_w)
    );

    pic_line_strobe u_slv_strb (
        .en   (s_en),
        .line (slv_win_line),
        .trig (slv_trig),
        .aeoi (slv_aeoi),
        .rot  (slv_rot_aeoi),
        .upd  (s_upd_w)
    );

    always_comb begin
        accept = ack_req & ~st_q.vld;
        m_en   = accept & mst_win_vld;
        s_en   = m_en & (mst_win_line == CAS) & slv_win_vld;

        st_d       = '0;
        st_d.vld   = accept;
        st_d.irq   = mst_win_vld & ~accept & ~st_q.vld;
        st_d.m_upd = m_upd_w;
        st_d.s_upd = s_upd_w;
        if (accept) begin
            if (!mst_win_vld)
                st_d.vec = {mst_base, SPUR};
            else if (mst_win_line != CAS)
                st_d.vec = {mst_base, mst_win_line};
            else if (slv_win_vld)
                st_d.vec = {slv_base, slv_win_line};
            else
                st_d.vec = {slv_base, SPUR};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq     = st_q.irq;
    assign vec_out     = st_q.vec;
    assign vec_vld     = st_q.vld;
    assign mst_irr_clr = st_q.m_upd.irr_clr;
    assign mst_isr_set = st_q.m_upd.isr_set;
    assign mst_rot_wr  = st_q.m_upd.rot_wr;
    assign mst_rot_val = st_q.m_upd.rot_val;
    assign slv_irr_clr = st_q.s_upd.irr_clr;
    assign slv_isr_set = st_q.s_upd.isr_set;
    assign slv_rot_wr  = st_q.s_upd.rot_wr;
    assign slv_rot_val = st_q.s_upd.rot_val;

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |=> !vec_vld); // R3
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> !cpu_irq); // R2
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_vld |-> (mst_isr_set == '0 && slv_isr_set == '0 && mst_irr_clr == '0
                      && slv_irr_clr == '0 && !mst_rot_wr && !slv_rot_wr)); // R3
    AST_AEOI_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld && $past(mst_aeoi)) |-> mst_isr_set == '0); // R9
    AST_ISR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mst_isr_set) && $onehot0(slv_isr_set)); // R9
    AST_SLV_VIA_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld && (slv_rot_wr || slv_isr_set != '0 || slv_irr_clr != '0))
            |-> $past(mst_win_line) == CAS); // R5
endmodule

// File: tb/sim_pic_ack_seq.sv
`timescale 1ns/1ps
module sim_pic_ack_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mst_win_vld = 0, slv_win_vld = 0;
    logic [2:0] mst_win_line = 0, slv_win_line = 0;
    logic [4:0] mst_base = 5'h01, slv_base = 5'h0E;
    logic       mst_aeoi = 0, slv_aeoi = 0, mst_rot_aeoi = 0, slv_rot_aeoi = 0;
    logic [7:0] mst_trig = 0, slv_trig = 0;
    logic       ack_req = 0;
    logic       cpu_irq, vec_vld, cas_pulse, mst_rot_wr, slv_rot_wr;
    logic [7:0] vec_out, mst_irr_clr, mst_isr_set, slv_irr_clr, slv_isr_set;
    logic [2:0] mst_rot_val, slv_rot_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pic_ack_seq u0 (.*);

    // {mwv, ml, swv, sl, mtrig, strig, maeoi, mrot, saeoi, srot, exp_vec}
    localparam int NV = 9;
    localparam logic [35:0] TBL [NV] = '{
        {1'b1, 3'd0, 1'b0, 3'd0, 8'h00, 8'h00, 4'b0000, 8'h08}, // R4
        {1'b1, 3'd5, 1'b0, 3'd0, 8'h20, 8'h00, 4'b0000, 8'h0D}, // R4 R8
        {1'b1, 3'd2, 1'b1, 3'd4, 8'h00, 8'h00, 4'b0000, 8'h74}, // R5
        {1'b1, 3'd2, 1'b0, 3'd0, 8'h00, 8'h00, 4'b0000, 8'h77}, // R6
        {1'b0, 3'd3, 1'b1, 3'd1, 8'h00, 8'h00, 4'b1111, 8'h0F}, // R7
        {1'b1, 3'd7, 1'b0, 3'd0, 8'h00, 8'h00, 4'b1100, 8'h0F}, // R10 wrap
        {1'b1, 3'd2, 1'b1, 3'd6, 8'h00, 8'h40, 4'b0011, 8'h76}, // R5 R8 R10
        {1'b1, 3'd3, 1'b0, 3'd0, 8'h00, 8'h00, 4'b1000, 8'h0B}, // R9
        {1'b1, 3'd2, 1'b1, 3'd0, 8'h04, 8'h00, 4'b1100, 8'h70}  // R8 R10
    };

    function automatic logic [19:0] exp_upd(input logic en, input logic [2:0] l,
                                            input logic [7:0] trig, input logic ae,
                                            input logic rt);
        logic [7:0] sel;
        logic [19:0] r;
        sel = en ? (8'h01 << l) : 8'h00;
        r[19:12] = sel & ~trig;
        r[11:4]  = ae ? 8'h00 : sel;
        r[3]     = en & ae & rt;
        r[2:0]   = (en & ae & rt) ? l + 3'd1 : 3'd0;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state R2 R3 R1
        chk("R2 reset irq", 32'(cpu_irq), 0);
        chk("R3 reset vld", 32'(vec_vld), 0);
        chk("R1 reset cas", 32'(cas_pulse), 0);
        rst_n = 1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [35:0] e;
            logic m_en, s_en;
            e = TBL[i];
            {mst_win_vld, mst_win_line, slv_win_vld, slv_win_line} = e[35:28];
            mst_trig = e[27:20]; slv_trig = e[19:12];
            {mst_aeoi, mst_rot_aeoi, slv_aeoi, slv_rot_aeoi} = e[11:8];
            ack_req = 1;
            @(negedge clk);
            ack_req = 0;
            m_en = e[35];
            s_en = e[35] && e[34:32] == 3'd2 && e[31];
            chk("R3 vld", 32'(vec_vld), 1);
            chk("R4-7 vec", 32'(vec_out), 32'(e[7:0]));
            chk("R8 R9 R10 mst upd",
                32'({mst_irr_clr, mst_isr_set, mst_rot_wr, mst_rot_val}),
                32'(exp_upd(m_en, e[34:32], e[27:20], e[11], e[10])));
            chk("R8 R9 R10 slv upd",
                32'({slv_irr_clr, slv_isr_set, slv_rot_wr, slv_rot_val}),
                32'(exp_upd(s_en, e[30:28], e[19:12], e[9], e[8])));
            @(negedge clk);
            chk("R3 vld drop", 32'(vec_vld), 0);
            chk("R3 strobes idle", 32'({mst_isr_set, slv_isr_set, mst_irr_clr, slv_irr_clr}), 0);
        end

        // R1 cascade alternation
        mst_win_vld = 0; slv_win_vld = 0;
        repeat (2) @(negedge clk);
        chk("R1 idle", 32'(cas_pulse), 0);
        slv_win_vld = 1;
        @(negedge clk); chk("R1 first", 32'(cas_pulse), 1);
        @(negedge clk); chk("R1 second", 32'(cas_pulse), 0);
        @(negedge clk); chk("R1 third", 32'(cas_pulse), 1);
        @(negedge clk); chk("R1 fourth", 32'(cas_pulse), 0);
        slv_win_vld = 0;
        @(negedge clk); @(negedge clk); chk("R1 stop", 32'(cas_pulse), 0);

        // R2 irq follow and hold-off, R3 double ack ignored
        mst_win_vld = 1; mst_win_line = 3'd1; mst_aeoi = 0; mst_trig = 0;
        @(negedge clk); chk("R2 irq follows", 32'(cpu_irq), 1);
        ack_req = 1;
        @(negedge clk);
        chk("R2 irq low at vld", 32'(cpu_irq), 0);
        chk("R3 first ack", 32'(vec_vld), 1);
        @(negedge clk);
        ack_req = 0;
        chk("R3 second ack ignored", 32'(vec_vld), 0);
        chk("R2 irq still low", 32'(cpu_irq), 0);
        @(negedge clk);
        chk("R3 no late vld", 32'(vec_vld), 0);
        chk("R2 irq resumes", 32'(cpu_irq), 1);
        mst_win_vld = 0;
        @(negedge clk); chk("R2 irq clears", 32'(cpu_irq), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule